// File: doc/BRIEF.md
# Aliased Model-Specific Register Access Unit

This unit serves read and write requests to a bank of 32 model-specific register slots, each 64 bits wide. A request carries a 32-bit index, a read/write select, a privilege flag and, for writes, 64 bits of data. The range check treats the index as a two's-complement number and rejects anything above 0x14. Every index with bit 31 set therefore passes, and its low five bits choose the slot. The whole upper half of the index space mirrors the 32 slots. In the low range, indices 0x03, 0x0A and 0x0F are rejected. Their upper-range mirrors are served normally.

Each slot has an access attribute: read/write, read-only, write-only, or write-only-and-discarded. Each slot also has a readable width. Bits at or above that width read as zero. A read of a write-only slot returns twice the slot number in the low word and zero in the high word. Storage is sixty-four 32-bit words, with slot n in words 2n (low half) and 2n+1 (high half). A request moves through a fixed sequence of states and ends in one of two outcomes. A one-cycle `rsp_done` pulse marks a completed request, and a one-cycle `rsp_fault` pulse marks a rejected one.

The state machine has six states:
- IDLE accepts a request.
- DECODE judges it: a rejected request goes to FAULT, an accepted one goes to LO.
- FAULT returns to IDLE.
- LO accesses the low word and moves to HI.
- HI accesses the high word and moves to DONE.
- DONE returns to IDLE.

`req_valid` is only looked at in IDLE.

Top module: `modreg_gate`

## Requirements
- R1: After reset, `rsp_done` and `rsp_fault` are low. Slots 0x18 and 0x1C read 0x4, and slot 0x1E reads 0.
- R2: A request with `priv_ok` low faults. A faulting read returns `rsp_rdata` = 0.
- R3: An index from 0x15 to 0x7FFFFFFF faults. An index from 0x00 to 0x14, other than the three in R4, completes.
- R4: Low-range indices 0x03, 0x0A and 0x0F fault.
- R5: Any index with bit 31 set completes and addresses slot index[4:0]. That slot is the same storage as the low-range index of the same number.
- R6: The upper-range mirrors of slots 0x03, 0x0A and 0x0F complete without fault.
- R7: Slot 0x0F and slots 0x15 to 0x17 are write-only. A read of any of them returns {32'h0, 2*slot}, for example 0x1E for slot 0x0F. Writes to them complete without fault, and writes to 0x15 to 0x17 are discarded.
- R8: Slots 0x18, 0x19, 0x1A and 0x1C are read-only. A write to one completes without fault and leaves its contents unchanged.
- R9: Readable widths are:
  - 11 bits for slots 0x19, 0x1A and 0x1B;
  - 32 bits for slots 0x18 and 0x1C to 0x1F;
  - 64 bits for all others.
  Bits at or above the width read as 0.
- R10: A faulting write changes no storage.
- R11: A read/write slot stores all 64 written bits, low half and high half independently, up to its readable width.
- R12: Relative to the clock edge that accepts a request in IDLE, `rsp_fault` is high in the 2nd cycle after it and `rsp_done` in the 4th. Each pulse lasts one cycle, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled in IDLE |
| req_write | input | 1 | 1 = write, 0 = read |
| priv_ok | input | 1 | Requester is privileged |
| req_index | input | 32 | Register index |
| req_wdata | input | 64 | Write data |
| rsp_rdata | output | 64 | Read data, valid with `rsp_done` and held afterwards |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 1 | One-cycle fault pulse |

## Verification
Every result of this unit has a fixed latency: a fault two cycles after the accepting edge, and a completion with its read data four cycles after it. The bench drives each request on a falling edge and counts falling edges until a strobe appears. It requires that count to be exactly 2 or 4 and samples `rsp_rdata` at that same falling edge. It then looks one falling edge later to confirm the strobe has dropped. Effects that cannot be seen directly, such as ignored or faulting writes, are checked with a following read of the affected slot through the normal request path.

// File: rtl/modreg_pkg.sv
package modreg_pkg;

    typedef enum logic [1:0] {
        ATTR_RW   = 2'd0,
        ATTR_RO   = 2'd1,
        ATTR_WO   = 2'd2,
        ATTR_NULL = 2'd3
    } slot_attr_e;

    function automatic slot_attr_e slot_attr(input logic [4:0] s);
        slot_attr_e a;
        case (s)
            5'h0F, 5'h15, 5'h16, 5'h17: a = (s == 5'h0F) ? ATTR_WO : ATTR_NULL;
            5'h18, 5'h19, 5'h1A, 5'h1C: a = ATTR_RO;
            default:                    a = ATTR_RW;
        endcase
        return a;
    endfunction

    function automatic logic [6:0] slot_width(input logic [4:0] s);
        logic [6:0] w;
        case (s)
            5'h19, 5'h1A, 5'h1B:               w = 7'd11;
            5'h18, 5'h1C, 5'h1D, 5'h1E, 5'h1F: w = 7'd32;
            default:                           w = 7'd64;
        endcase
        return w;
    endfunction

    function automatic logic [31:0] word_reset(input logic [5:0] w);
        logic [31:0] v;
        case (w)
            6'd48, 6'd56: v = 32'h0000_0004;
            default:      v = 32'h0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/modreg_decode.sv
module modreg_decode
    import modreg_pkg::*;
#(
    parameter int          IDX_W   = 32,
    parameter int          SLOT_W  = 5,
    parameter logic [31:0] MAX_LOW = 32'h14
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic              priv,
    output logic              reject,
    output logic [SLOT_W-1:0] slot,
    output slot_attr_e        attr
);
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(MAX_LOW);

    logic over_range;
    logic blocked;

    always_comb begin
        over_range = $signed(idx) > $signed(LIMIT);
        blocked    = (idx == IDX_W'(32'h03)) || (idx == IDX_W'(32'h0A)) ||
                     (idx == IDX_W'(32'h0F));
        reject     = !priv || over_range || blocked;
        slot       = idx[SLOT_W-1:0];
        attr       = slot_attr(5'(slot));
    end
endmodule

// File: rtl/modreg_store.sv
module modreg_store
    import modreg_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= WORD_W'(word_reset(6'(i)));
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/modreg_gate.sv
module modreg_gate
    import modreg_pkg::*;
#(
    parameter int          IDX_W   = 32,
    parameter int          DATA_W  = 64,
    parameter int          SLOT_W  = 5,
    parameter logic [31:0] MAX_LOW = 32'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              priv_ok,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              rsp_fault
);
    localparam int WORD_W = DATA_W / 2;
    localparam int ADDR_W = SLOT_W + 1;

    typedef enum logic [2:0] {
        S_IDLE, S_DECODE, S_FAULT, S_LO, S_HI, S_DONE
    } state_e;

    state_e state, state_nx;

    logic              wr_q;
    logic              priv_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] wdata_q;
    logic [WORD_W-1:0] lo_q;
    logic [DATA_W-1:0] rdata_q;

    logic              reject;
    logic [SLOT_W-1:0] slot;
    slot_attr_e        attr;

    logic              half_hi;
    logic              st_we;
    logic [ADDR_W-1:0] st_addr;
    logic [WORD_W-1:0] st_wdata;
    logic [WORD_W-1:0] st_rdata;
    logic [6:0]        width;
    logic [DATA_W-1:0] rd_mask;
    logic [WORD_W-1:0] wo_pattern;

    modreg_decode #(
        .IDX_W  (IDX_W),
        .SLOT_W (SLOT_W),
        .MAX_LOW(MAX_LOW)
    ) u_decode (
        .idx   (idx_q),
        .priv  (priv_q),
        .reject(reject),
        .slot  (slot),
        .attr  (attr)
    );

    modreg_store #(
        .ADDR_W(ADDR_W),
        .WORD_W(WORD_W)
    ) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (st_we),
        .addr (st_addr),
        .wdata(st_wdata),
        .rdata(st_rdata)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (req_valid) state_nx = S_DECODE;
            S_DECODE: state_nx = reject ? S_FAULT : S_LO;
            S_FAULT:  state_nx = S_IDLE;
            S_LO:     state_nx = S_HI;
            S_HI:     state_nx = S_DONE;
            S_DONE:   state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // word access path
    always_comb begin
        half_hi    = (state == S_HI);
        st_addr    = {slot, half_hi};
        st_wdata   = half_hi ? wdata_q[DATA_W-1:WORD_W] : wdata_q[WORD_W-1:0];
        st_we      = (state == S_LO || state == S_HI) && wr_q &&
                     (attr == ATTR_RW || attr == ATTR_WO);
        width      = slot_width(5'(slot));
        rd_mask    = (width >= 7'(DATA_W)) ? '1 : ((DATA_W'(1) << width) - DATA_W'(1));
        wo_pattern = WORD_W'({slot, 1'b0});
    end

    // request capture and read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            priv_q  <= 1'b0;
            idx_q   <= '0;
            wdata_q <= '0;
            lo_q    <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    wr_q    <= req_write;
                    priv_q  <= priv_ok;
                    idx_q   <= req_index;
                    wdata_q <= req_wdata;
                end
                S_DECODE: if (reject && !wr_q) rdata_q <= '0;
                S_LO:     lo_q <= st_rdata;
                S_HI: if (!wr_q) begin
                    if (attr == ATTR_WO || attr == ATTR_NULL)
                        rdata_q <= {{WORD_W{1'b0}}, wo_pattern};
                    else
                        rdata_q <= {st_rdata, lo_q} & rd_mask;
                end
                default: ;
            endcase
        end
    end

    assign rsp_rdata = rdata_q;
    assign rsp_done  = (state == S_DONE);
    assign rsp_fault = (state == S_FAULT);
endmodule

// File: rtl/modreg_gate_chk.sv
module modreg_gate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic        priv_ok,
    input logic [31:0] req_index,
    input logic [63:0] req_wdata,
    input logic [63:0] rsp_rdata,
    input logic        rsp_done,
    input logic        rsp_fault
);
    logic        busy;
    logic [2:0]  cnt;
    logic        cap_wr;
    logic        cap_priv;
    logic [31:0] cap_idx;
    logic        cap_wo;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cnt      <= '0;
            cap_wr   <= 1'b0;
            cap_priv <= 1'b0;
            cap_idx  <= '0;
        end else if (!busy) begin
            if (req_valid) begin
                busy     <= 1'b1;
                cnt      <= 3'd1;
                cap_wr   <= req_write;
                cap_priv <= priv_ok;
                cap_idx  <= req_index;
            end
        end else if (rsp_done || rsp_fault) begin
            busy <= 1'b0;
        end else if (cnt != 3'd7) begin
            cnt <= cnt + 3'd1;
        end
    end

    assign cap_wo = (cap_idx[4:0] == 5'h0F) || (cap_idx[4:0] == 5'h15) ||
                    (cap_idx[4:0] == 5'h16) || (cap_idx[4:0] == 5'h17);

    p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_done && rsp_fault));
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    p_fault_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |=> !rsp_fault);
    p_fault_lat_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (busy && cnt == 3'd2));
    p_done_lat_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (busy && cnt == 3'd4));
    p_priv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> cap_priv);
    p_fault_rdata_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault && !cap_wr) |-> (rsp_rdata == 64'h0));
    p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !($signed(cap_idx) > 32'sh14));
    p_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !(cap_idx == 32'h03 || cap_idx == 32'h0A || cap_idx == 32'h0F));
    p_wo_pattern_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !cap_wr && cap_wo) |-> (rsp_rdata == {58'h0, cap_idx[4:0], 1'b0}));
    p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !cap_wr && cap_idx[4:0] == 5'h1B) |-> (rsp_rdata[63:11] == '0));

    logic unused_ok;
    assign unused_ok = ^req_wdata;
endmodule

bind modreg_gate modreg_gate_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .priv_ok  (priv_ok),
    .req_index(req_index),
    .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata),
    .rsp_done (rsp_done),
    .rsp_fault(rsp_fault)
);

// File: tb/modreg_gate_test.sv
`timescale 1ns/1ps
module modreg_gate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        priv_ok = 1'b0;
    logic [31:0] req_index = '0;
    logic [63:0] req_wdata = '0;
    logic [63:0] rsp_rdata;
    logic        rsp_done;
    logic        rsp_fault;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    modreg_gate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .priv_ok(priv_ok), .req_index(req_index), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .rsp_fault(rsp_fault)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // issue one request; checks R12 latency and pulse shape, returns outcome
    task automatic issue(input string req, input logic wr, input logic pv,
                         input logic [31:0] idx, input logic [63:0] wd,
                         input logic exp_fault, output logic [63:0] rd);
        int lat;
        logic f;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; priv_ok = pv; req_index = idx; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!(rsp_done || rsp_fault) && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        f  = rsp_fault;
        rd = rsp_rdata;
        chk({req, " fault"}, 64'(f), 64'(exp_fault));
        chk({"R12 latency ", req}, 64'(lat), exp_fault ? 64'd2 : 64'd4);
        chk("R12 exclusive strobes", 64'(rsp_done && rsp_fault), 64'd0);
        @(negedge clk);
        chk("R12 one-cycle pulse", 64'(rsp_done || rsp_fault), 64'd0);
    endtask

    task automatic rd_ok(input string req, input logic [31:0] idx, input logic [63:0] exp);
        logic [63:0] rd;
        issue(req, 1'b0, 1'b1, idx, '0, 1'b0, rd);
        chk({req, " rdata"}, rd, exp);
    endtask

    task automatic wr(input string req, input logic pv, input logic [31:0] idx,
                      input logic [63:0] wd, input logic exp_fault);
        logic [63:0] rd;
        issue(req, 1'b1, pv, idx, wd, exp_fault, rd);
    endtask

    task automatic rd_fault(input string req, input logic pv, input logic [31:0] idx);
        logic [63:0] rd;
        issue(req, 1'b0, pv, idx, '0, 1'b1, rd);
        chk({req, " rdata"}, rd, 64'h0);
    endtask

    task automatic t_reset;
        chk("R1 done low", 64'(rsp_done), 64'd0);
        chk("R1 fault low", 64'(rsp_fault), 64'd0);
        rd_ok("R1 slot18", 32'h8000_0018, 64'h4);
        rd_ok("R1 slot1C", 32'h8000_001C, 64'h4);
        rd_ok("R1 slot1E", 32'h8000_001E, 64'h0);
    endtask

    task automatic t_priv;
        wr("R11 wr slot0", 1'b1, 32'h0, 64'h0123_4567_89AB_CDEF, 1'b0);
        rd_ok("R11 rd slot0", 32'h0, 64'h0123_4567_89AB_CDEF);
        rd_fault("R2 unpriv read", 1'b0, 32'h0);
        wr("R2 unpriv write", 1'b0, 32'h8000_0000, '1, 1'b1);
        rd_ok("R10 slot0 kept", 32'h0, 64'h0123_4567_89AB_CDEF);
    endtask

    task automatic t_range;
        rd_fault("R3 idx15", 1'b1, 32'h15);
        rd_fault("R3 idx7FFFFFFF", 1'b1, 32'h7FFF_FFFF);
        wr("R3 wr idx14", 1'b1, 32'h14, 64'hA5A5_0000_0000_5A5A, 1'b0);
        rd_ok("R3 rd idx14", 32'h14, 64'hA5A5_0000_0000_5A5A);
    endtask

    task automatic t_blocked;
        rd_fault("R4 idx03", 1'b1, 32'h03);
        rd_fault("R4 idx0A", 1'b1, 32'h0A);
        rd_fault("R4 idx0F", 1'b1, 32'h0F);
        wr("R6 wr 80000003", 1'b1, 32'h8000_0003, 64'h3333_0000_1111_2222, 1'b0);
        rd_ok("R6 rd 80000003", 32'h8000_0003, 64'h3333_0000_1111_2222);
        rd_ok("R6 rd 8000000A", 32'h8000_000A, 64'h0);
    endtask

    task automatic t_alias;
        wr("R5 wr 80000005", 1'b1, 32'h8000_0005, 64'hDEAD_BEEF_CAFE_F00D, 1'b0);
        rd_ok("R5 rd 05", 32'h05, 64'hDEAD_BEEF_CAFE_F00D);
        rd_ok("R5 rd FFFFFFE5", 32'hFFFF_FFE5, 64'hDEAD_BEEF_CAFE_F00D);
        wr("R11 wr 02", 1'b1, 32'h02, 64'h8000_0001_0000_0000, 1'b0);
        rd_ok("R5 rd C0000002", 32'hC000_0002, 64'h8000_0001_0000_0000);
    endtask

    task automatic t_wo;
        rd_ok("R7 rd 8000000F", 32'h8000_000F, 64'h1E);
        wr("R7 wr 80000015", 1'b1, 32'h8000_0015, '1, 1'b0);
        rd_ok("R7 rd 80000015", 32'h8000_0015, 64'h2A);
        rd_ok("R7 rd A0000016", 32'hA000_0016, 64'h2C);
    endtask

    task automatic t_ro;
        wr("R8 wr slot18", 1'b1, 32'h8000_0018, '1, 1'b0);
        rd_ok("R8 rd slot18", 32'h8000_0018, 64'h4);
        wr("R8 wr slot19", 1'b1, 32'h8000_0019, '1, 1'b0);
        rd_ok("R8 rd slot19", 32'h8000_0019, 64'h0);
    endtask

    task automatic t_mask;
        wr("R9 wr 1B", 1'b1, 32'h8000_001B, '1, 1'b0);
        rd_ok("R9 rd 1B", 32'h8000_001B, 64'h7FF);
        wr("R9 wr 1E", 1'b1, 32'h8000_001E, '1, 1'b0);
        rd_ok("R9 rd 1E", 32'h8000_001E, 64'hFFFF_FFFF);
        wr("R9 wr 1D", 1'b1, 32'h8000_001D, '1, 1'b0);
        rd_ok("R9 rd 1D", 32'h8000_001D, 64'hFFFF_FFFF);
        wr("R9 wr 01", 1'b1, 32'h01, '1, 1'b0);
        rd_ok("R9 rd 01", 32'h8000_0001, '1);
    endtask

    task automatic t_faultwr;
        wr("R10 wr idx25", 1'b1, 32'h25, '1, 1'b1);
        rd_ok("R10 slot5 kept", 32'h05, 64'hDEAD_BEEF_CAFE_F00D);
        wr("R10 wr idx0F", 1'b1, 32'h0F, '1, 1'b1);
        wr("R10 wr idx03", 1'b1, 32'h03, '1, 1'b1);
        rd_ok("R10 slot3 kept", 32'h8000_0003, 64'h3333_0000_1111_2222);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_priv;
        t_range;
        t_blocked;
        t_alias;
        t_wo;
        t_ro;
        t_mask;
        t_faultwr;
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule